// File: doc/BRIEF.md
# Flash Program/Erase Control Sequencer

This block holds the 16-bit control word that software uses to start program and erase operations on an on-chip flash array. It also contains the small sequencer that launches each self-timed operation and follows it to the end. Software writes the word to choose an operation code and the erase/program meaning, and to set the write-enable and start bits. A legal start raises a one-cycle launch pulse toward the array, together with a decoded operation type. The start bit then reads 1 until the array reports completion.

The block refuses a start attempt that is not allowed and raises a sticky error flag instead. An attempt is refused when write-enable is low, when the code and erase bit do not form an implemented operation, or when an operation is already running. The read port is a plain combinational view of the stored control bits. The only reset is the power-on reset.

Top module: `flash_op_ctrl`

## Requirements
- R1: Control word layout: start at bit 15, write-enable at bit 14, error flag at bit 13, erase select at bit 6, operation code at bits 3:0. A bus write stores write-enable, erase select and code, and a read returns the stored values in the cycle after the write.
- R2: Bits 12:7 and 5:4 always read 0, whatever value is written to them.
- R3: Software cannot clear the start bit: a write with bit 15 at 0 while an operation runs leaves the start bit at 1.
- R4: A start attempt (a write with bit 15 at 1) whose written write-enable bit is 0 produces no launch pulse, leaves the start bit at 0 and sets the error flag.
- R5: A legal start attempt raises op_start for exactly one cycle, the cycle after the write. op_kind carries the decoded type from that cycle until the next legal start. The start bit reads 1 from the cycle after the write.
- R6: The start bit stays 1 until op_done is sampled high, and it reads 0 in the cycle after that. op_done has no effect while no operation runs.
- R7: With erase select 1, the codes decode to these op_kind values: 1111 gives 8 (bulk erase), 1101 gives 7 (general segment erase), 1100 gives 6 (secure segment erase), 0010 gives 5 (page erase), 0000 gives 4 (configuration byte erase).
- R8: With erase select 0, the codes decode to these op_kind values: 0011 gives 3 (word program), 0001 gives 2 (row program), 0000 gives 1 (configuration byte program).
- R9: Any other pairing of erase select and code, whether reserved or a no-operation, makes the start attempt improper. It causes no launch pulse, leaves the start bit at 0 and sets the error flag.
- R10: A start attempt while an operation runs sets the error flag and causes no second pulse, and the running operation continues.
- R11: The error flag is sticky. Only a bus write with bit 13 at 0 clears it. A write with bit 13 at 1 neither sets nor clears it, and a normal completion leaves it unchanged.
- R12: After power-on reset the read word is 0 and op_start is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low |
| bus_we | input | 1 | Write strobe for the control word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Current control word |
| op_start | output | 1 | One-cycle launch pulse to the array |
| op_kind | output | 4 | Decoded operation type of the last launch |
| op_done | input | 1 | Completion from the array's timer |

## Verification
Every result of a write appears one clock edge after the write strobe is sampled. This covers the readback value, the error flag, the start bit and the launch pulse, so the bench reads them at the falling edge right after that rising edge. The effect of op_done on the start bit also lags by one edge and is sampled in the same way. The bench works out the expected op_kind from the decode tables in the requirements, queues it, and pops the queue whenever op_start is seen. A pulse with no queued entry, a pulse lasting two cycles, or an entry left in the queue at the end counts as a miscompare.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;
    localparam int CW_W      = 16;
    localparam int CODE_W    = 4;
    localparam int KIND_W    = 4;
    localparam int BIT_START = 15;
    localparam int BIT_WREN  = 14;
    localparam int BIT_ERR   = 13;
    localparam int BIT_ERASE = 6;

    typedef enum logic [KIND_W-1:0] {
        KIND_NONE       = 4'd0,
        KIND_CFG_PROG   = 4'd1,
        KIND_ROW_PROG   = 4'd2,
        KIND_WORD_PROG  = 4'd3,
        KIND_CFG_ERASE  = 4'd4,
        KIND_PAGE_ERASE = 4'd5,
        KIND_SEC_ERASE  = 4'd6,
        KIND_GEN_ERASE  = 4'd7,
        KIND_BULK_ERASE = 4'd8
    } op_kind_e;

    typedef struct packed {
        logic              wren;
        logic              err;
        logic              erase;
        logic [CODE_W-1:0] code;
    } ctl_fields_t;

    typedef struct packed {
        logic     busy;
        logic     pulse;
        op_kind_e kind;
    } seq_state_t;
endpackage

// File: rtl/flash_op_decode.sv
module flash_op_decode
    import flash_ctl_pkg::*;
(
    input  logic              erase,
    input  logic [CODE_W-1:0] code,
    output op_kind_e          kind,
    output logic              legal
);
    always_comb begin
        kind = KIND_NONE;
        if (erase) begin
            unique case (code)
                4'b1111: kind = KIND_BULK_ERASE;
                4'b1101: kind = KIND_GEN_ERASE;
                4'b1100: kind = KIND_SEC_ERASE;
                4'b0010: kind = KIND_PAGE_ERASE;
                4'b0000: kind = KIND_CFG_ERASE;
                default: kind = KIND_NONE;
            endcase
        end else begin
            unique case (code)
                4'b0011: kind = KIND_WORD_PROG;
                4'b0001: kind = KIND_ROW_PROG;
                4'b0000: kind = KIND_CFG_PROG;
                default: kind = KIND_NONE;
            endcase
        end
        legal = (kind != KIND_NONE);
    end
endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
    import flash_ctl_pkg::*;
(
    input  logic     clk,
    input  logic     por_n,
    input  logic     start_req,
    input  logic     start_ok,
    input  op_kind_e kind_in,
    input  logic     op_done,
    output logic     busy,
    output logic     start_pulse,
    output op_kind_e kind_out,
    output logic     bad_attempt
);
    seq_state_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.pulse   = 1'b0;
        bad_attempt = 1'b0;
        if (s_q.busy && op_done) begin
            s_d.busy = 1'b0;
        end
        if (start_req) begin
            if (s_q.busy || !start_ok) begin
                bad_attempt = 1'b1;
            end else begin
                s_d.busy  = 1'b1;
                s_d.pulse = 1'b1;
                s_d.kind  = kind_in;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            s_q <= '{busy: 1'b0, pulse: 1'b0, kind: KIND_NONE};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy        = s_q.busy;
    assign start_pulse = s_q.pulse;
    assign kind_out    = s_q.kind;
endmodule

// File: rtl/flash_op_ctrl.sv
module flash_op_ctrl
    import flash_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              bus_we,
    input  logic [CW_W-1:0]   bus_wdata,
    output logic [CW_W-1:0]   bus_rdata,
    output logic              op_start,
    output logic [KIND_W-1:0] op_kind,
    input  logic              op_done
);
    ctl_fields_t f_d, f_q;

    logic     w_start, w_wren, w_err, w_erase;
    logic [CODE_W-1:0] w_code;
    op_kind_e dec_kind, seq_kind;
    logic     dec_legal, busy, bad_attempt;
    logic     unused_wbits;

    assign w_start = bus_wdata[BIT_START];
    assign w_wren  = bus_wdata[BIT_WREN];
    assign w_err   = bus_wdata[BIT_ERR];
    assign w_erase = bus_wdata[BIT_ERASE];
    assign w_code  = bus_wdata[CODE_W-1:0];
    assign unused_wbits = ^{bus_wdata[BIT_ERR-1:BIT_ERASE+1],
                            bus_wdata[BIT_ERASE-1:CODE_W]};

    flash_op_decode u_dec (
        .erase (w_erase),
        .code  (w_code),
        .kind  (dec_kind),
        .legal (dec_legal)
    );

    flash_op_seq u_seq (
        .clk         (clk),
        .por_n       (por_n),
        .start_req   (bus_we && w_start),
        .start_ok    (w_wren && dec_legal),
        .kind_in     (dec_kind),
        .op_done     (op_done),
        .busy        (busy),
        .start_pulse (op_start),
        .kind_out    (seq_kind),
        .bad_attempt (bad_attempt)
    );

    always_comb begin
        f_d = f_q;
        if (bus_we) begin
            f_d.wren  = w_wren;
            f_d.erase = w_erase;
            f_d.code  = w_code;
            f_d.err   = f_q.err & w_err;
        end
        if (bad_attempt) begin
            f_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    always_comb begin
        bus_rdata                  = '0;
        bus_rdata[BIT_START]       = busy;
        bus_rdata[BIT_WREN]        = f_q.wren;
        bus_rdata[BIT_ERR]         = f_q.err;
        bus_rdata[BIT_ERASE]       = f_q.erase;
        bus_rdata[CODE_W-1:0]      = f_q.code;
    end

    assign op_kind = seq_kind;
endmodule

// File: rtl/flash_op_ctrl_chk.sv
module flash_op_ctrl_chk
    import flash_ctl_pkg::*;
(
    input logic              clk,
    input logic              por_n,
    input logic              bus_we,
    input logic [CW_W-1:0]   bus_wdata,
    input logic [CW_W-1:0]   bus_rdata,
    input logic              op_start,
    input logic [KIND_W-1:0] op_kind,
    input logic              op_done
);
    p_unimpl_zero_r2: assert property (@(posedge clk) disable iff (!por_n)
        (bus_rdata[12:7] == '0) && (bus_rdata[5:4] == '0));

    p_no_clear_by_sw_r3: assert property (@(posedge clk) disable iff (!por_n)
        bus_rdata[BIT_START] && !op_done |=> bus_rdata[BIT_START]);

    p_wren_low_blocks_r4: assert property (@(posedge clk) disable iff (!por_n)
        bus_we && bus_wdata[BIT_START] && !bus_wdata[BIT_WREN]
        |=> !op_start && bus_rdata[BIT_ERR]);

    p_pulse_one_cycle_r5: assert property (@(posedge clk) disable iff (!por_n)
        op_start |=> !op_start);

    p_pulse_follows_write_r5: assert property (@(posedge clk) disable iff (!por_n)
        op_start |-> $past(bus_we && bus_wdata[BIT_START] && bus_wdata[BIT_WREN]));

    p_kind_held_r5: assert property (@(posedge clk) disable iff (!por_n)
        bus_rdata[BIT_START] |=> $stable(op_kind));

    p_done_clears_r6: assert property (@(posedge clk) disable iff (!por_n)
        bus_rdata[BIT_START] && op_done |=> !bus_rdata[BIT_START]);

    p_busy_retry_errs_r10: assert property (@(posedge clk) disable iff (!por_n)
        bus_rdata[BIT_START] && bus_we && bus_wdata[BIT_START]
        |=> !op_start && bus_rdata[BIT_ERR]);

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!por_n)
        bus_rdata[BIT_ERR] && !(bus_we && !bus_wdata[BIT_ERR]) |=> bus_rdata[BIT_ERR]);
endmodule

bind flash_op_ctrl flash_op_ctrl_chk chk_i (
    .clk       (clk),
    .por_n     (por_n),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .op_start  (op_start),
    .op_kind   (op_kind),
    .op_done   (op_done)
);

// File: tb/flash_op_ctrl_tb_top.sv
module flash_op_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        op_start;
    logic [3:0]  op_kind;
    logic        op_done = 1'b0;

    int vectors = 0;
    int fails = 0;
    logic [3:0] exp_q [$];
    logic prev_start = 1'b0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_op_ctrl dut_i (
        .clk(clk), .por_n(por_n), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .op_start(op_start), .op_kind(op_kind), .op_done(op_done)
    );

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    // Expected op_kind from the R7/R8 tables; 0 means improper (R9)
    function automatic logic [3:0] exp_kind(logic e, logic [3:0] c);
        if (e) begin
            case (c)
                4'hF: return 4'd8;
                4'hD: return 4'd7;
                4'hC: return 4'd6;
                4'h2: return 4'd5;
                4'h0: return 4'd4;
                default: return 4'd0;
            endcase
        end
        case (c)
            4'h3: return 4'd3;
            4'h1: return 4'd2;
            4'h0: return 4'd1;
            default: return 4'd0;
        endcase
    endfunction

    task automatic bus_write(logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
    endtask

    // Monitor: pops the scoreboard on every launch pulse (R5, R7, R8)
    always @(negedge clk) begin
        if (por_n) begin
            if (op_start) begin
                vectors++;
                if (prev_start) begin
                    fails++;
                    $display("FAIL R5: op_start high two cycles, actual 1 expected 0");
                end else if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R9: unexpected pulse kind %0d, expected no pulse", op_kind);
                end else begin
                    logic [3:0] e;
                    e = exp_q.pop_front();
                    if (op_kind !== e) begin
                        fails++;
                        $display("FAIL R7/R8 kind: actual %0d expected %0d", op_kind, e);
                    end
                end
            end
            prev_start = op_start;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R12 reset rdata", bus_rdata, 16'h0000);
        chk("R12 reset op_start", {15'd0, op_start}, 16'h0000);
        por_n = 1'b1;
        @(negedge clk);

        // R1, R2, R11: fields stored, unimplemented bits zero, write of 1 does not set err
        bus_write(16'h7FF5);
        chk("R1 R2 R11 readback", bus_rdata, 16'h4045);
        bus_write(16'h0000);
        chk("R1 clear fields", bus_rdata, 16'h0000);

        // R7, R8, R9: every erase/code pairing
        for (int e = 0; e < 2; e++) begin
            for (int c = 0; c < 16; c++) begin
                logic [15:0] w;
                logic [3:0]  k;
                w = 16'hC000 | (16'(e) << 6) | 16'(c);
                k = exp_kind(e[0], c[3:0]);
                if (k != 0) begin
                    exp_q.push_back(k);
                    bus_write(w);
                    chk("R5 start bit set", bus_rdata, w);
                    pulse_done();
                    chk("R6 start cleared", bus_rdata, w & 16'h7FFF);
                end else begin
                    bus_write(w);
                    chk("R9 improper start", bus_rdata, (w & 16'h7FFF) | 16'h2000);
                    bus_write(16'h4000);
                    chk("R11 err cleared by 0", bus_rdata, 16'h4000);
                end
            end
        end

        // R3, R10, R11
        exp_q.push_back(4'd3);
        bus_write(16'hC003);
        bus_write(16'h4003);
        chk("R3 sw cannot clear start", bus_rdata, 16'hC003);
        bus_write(16'hC041);
        chk("R10 start while busy", bus_rdata, 16'hE041);
        repeat (3) @(negedge clk);
        chk("R6 busy held without done", bus_rdata, 16'hE041);
        chk("R5 kind held", {12'd0, op_kind}, 16'h0003);
        pulse_done();
        chk("R11 err survives completion", bus_rdata, 16'h6041);
        bus_write(16'h6041);
        chk("R11 write 1 keeps err", bus_rdata, 16'h6041);
        bus_write(16'h4041);
        chk("R11 write 0 clears err", bus_rdata, 16'h4041);

        // R4: write-enable low
        bus_write(16'h804F);
        chk("R4 wren low start", bus_rdata, 16'h204F);
        bus_write(16'h0000);

        // R6: done while idle ignored
        pulse_done();
        chk("R6 idle done ignored", bus_rdata, 16'h0000);

        repeat (3) @(negedge clk);
        chk("R5 queue drained", 16'(exp_q.size()), 16'h0000);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule